// File: doc/BRIEF.md
# Control Register Read-Modify-Write Sequencer

This block carries out the three atomic control-register instructions of a processor pipeline: swap (read-write), bit-set (read-set) and bit-clear (read-clear). It takes one request at a time. A request is a 12-bit register address, a source operand, a 2-bit operation code, a flag that marks the source register as the hardwired zero register, and the privilege level of the hart that issued it. The block reads the register through an external read port and decides whether the access is allowed. In the following cycle it issues the write, if the access needs one, and returns the old register value to the pipeline. If the access is not allowed, it raises an illegal-instruction indication.

The register storage sits outside the block, behind a plain port. The block drives an address and read enable. The storage answers in the same cycle with the data and a hit flag that says whether any register decodes that address. On the write side the block drives enable, address and data. Legality masking of individual fields is left to the storage. Privilege levels are numbered U=0, S=1, reserved=2, M=3 and are compared as unsigned numbers.

Top module: `csr_rmw_unit`

## Requirements
- R1: The least privilege a register requires is address bits [9:8]. A request whose privilege is numerically lower than this is illegal.
- R2: An address with bits [11:10] equal to 2'b11 names a read-only register. A request that would write it is illegal. A request to it that does not write (set or clear with the zero-source flag) is legal.
- R3: Operation code 2'b01 (swap) always writes the source operand and always counts as a write, even when the zero-source flag is set.
- R4: Operation codes 2'b10 (set) and 2'b11 (clear) with the zero-source flag set issue no write and leave the register unchanged, whatever the source operand value is.
- R5: On a legal request, rsp_data carries the register value as read before the update.
- R6: The written value is old|src for set and old&~src for clear.
- R7: A request to an address for which rd_hit is low is illegal.
- R8: Operation code 2'b00 is not a register operation and is illegal.
- R9: On an illegal request wr_en stays low, rsp_illegal is high for exactly the one cycle of rsp_done, and rsp_data is zero.
- R10: Timing, counting from the rising edge that accepts a request (req_valid with req_ready high):
  - rd_en is high for exactly the next cycle.
  - rsp_done, together with any write, is high for exactly the cycle after that.
  - req_ready is high only while no request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle |
| req_addr | input | 12 | Register address |
| req_src | input | XLEN | Source operand |
| req_op | input | 2 | 00 none, 01 swap, 10 set, 11 clear |
| req_src_zero | input | 1 | Source register is the zero register |
| req_priv | input | 2 | Current privilege level |
| rd_en | output | 1 | Read strobe to storage |
| rd_addr | output | 12 | Read address |
| rd_data | input | XLEN | Read data, same cycle |
| rd_hit | input | 1 | Address decodes to a register |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 12 | Write address |
| wr_data | output | XLEN | Updated value |
| rsp_done | output | 1 | Result valid, one cycle |
| rsp_data | output | XLEN | Old register value |
| rsp_illegal | output | 1 | Illegal-instruction indication |

## Verification
The bench probes set and clear with the zero-source flag but a nonzero operand. A design that keyed on the operand instead of the flag would write the register, and a later read-back would show it changed. It reads read-only registers with non-writing forms and tries writes to them. A design that mixed up these cases would either trap on a plain read or modify the read-only register. It tests privilege at the exact boundary and one level below, and it tests undecoded addresses and the null operation code. A design that skipped any of these checks would return data or write where it should trap. Every response is checked at its exact cycle against a shadow model, so a design that returned the post-update value or took an extra cycle would mismatch.

// File: rtl/csr_rmw_pkg.sv
package csr_rmw_pkg;

    localparam int unsigned CSR_ADDR_W = 12;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_SWAP  = 2'b01,
        OP_SET   = 2'b10,
        OP_CLEAR = 2'b11
    } csr_op_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'b00,
        ST_CHECK = 2'b01,
        ST_WRITE = 2'b10
    } seq_state_e;

    typedef struct packed {
        logic illegal;
        logic do_wr;
    } verdict_t;

    // Least privilege level encoded in the address high nibble.
    function automatic logic [1:0] need_priv(input logic [3:0] addr_hi);
        return addr_hi[1:0];
    endfunction

    // Read-only registers live in the top quarter of the address space.
    function automatic logic is_read_only(input logic [3:0] addr_hi);
        return addr_hi[3:2] == 2'b11;
    endfunction

    // Whether an operation modifies the register.
    function automatic logic op_writes(input csr_op_e op, input logic src_zero);
        return (op == OP_SWAP) || (((op == OP_SET) || (op == OP_CLEAR)) && !src_zero);
    endfunction

endpackage

// File: rtl/csr_seq_ctrl.sv
module csr_seq_ctrl
    import csr_rmw_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    output seq_state_e state,
    output logic       ready,
    output logic       accept
);

    seq_state_e state_d;

    assign ready  = (state == ST_IDLE);
    assign accept = ready && req_valid;

    always_comb begin
        case (state)
            ST_IDLE:  state_d = req_valid ? ST_CHECK : ST_IDLE;
            ST_CHECK: state_d = ST_WRITE;
            ST_WRITE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_d;
    end

    // R10: accepted request moves to the check phase next cycle
    a_r10_accept_to_check: assert property (@(posedge clk) disable iff (rst)
        accept |=> (state == ST_CHECK));

    // R10: check phase is always followed by the write/response phase
    a_r10_check_to_write: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CHECK) |=> (state == ST_WRITE));

endmodule

// File: rtl/csr_perm_check.sv
module csr_perm_check
    import csr_rmw_pkg::*;
(
    input  logic [3:0] addr_hi,
    input  csr_op_e    op,
    input  logic       src_zero,
    input  logic [1:0] priv,
    input  logic       hit,
    output verdict_t   verdict
);

    logic writes;
    logic bad_priv;
    logic bad_ro;

    always_comb begin
        writes          = op_writes(op, src_zero);
        bad_priv        = priv < need_priv(addr_hi);
        bad_ro          = writes && is_read_only(addr_hi);
        verdict.illegal = !hit || (op == OP_NONE) || bad_priv || bad_ro;
        verdict.do_wr   = writes && !verdict.illegal;
    end

endmodule

// File: rtl/csr_update_calc.sv
module csr_update_calc
    import csr_rmw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  csr_op_e           op,
    input  logic [XLEN-1:0]   old_val,
    input  logic [XLEN-1:0]   src,
    output logic [XLEN-1:0]   new_val
);

    always_comb begin
        case (op)
            OP_SWAP:  new_val = src;
            OP_SET:   new_val = old_val | src;
            OP_CLEAR: new_val = old_val & ~src;
            default:  new_val = old_val;
        endcase
    end

endmodule

// File: rtl/csr_rmw_unit.sv
module csr_rmw_unit
    import csr_rmw_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [CSR_ADDR_W-1:0] req_addr,
    input  logic [XLEN-1:0]       req_src,
    input  logic [1:0]            req_op,
    input  logic                  req_src_zero,
    input  logic [1:0]            req_priv,
    output logic                  rd_en,
    output logic [CSR_ADDR_W-1:0] rd_addr,
    input  logic [XLEN-1:0]       rd_data,
    input  logic                  rd_hit,
    output logic                  wr_en,
    output logic [CSR_ADDR_W-1:0] wr_addr,
    output logic [XLEN-1:0]       wr_data,
    output logic                  rsp_done,
    output logic [XLEN-1:0]       rsp_data,
    output logic                  rsp_illegal
);

    localparam int unsigned HI_LSB = CSR_ADDR_W - 4;

    seq_state_e            state;
    logic                  accept;

    logic [CSR_ADDR_W-1:0] addr_q;
    logic [XLEN-1:0]       src_q;
    csr_op_e               op_q;
    logic                  zero_q;
    logic [1:0]            priv_q;

    logic [XLEN-1:0]       old_q;
    logic [XLEN-1:0]       new_q;
    verdict_t              verdict_q;

    verdict_t              verdict_c;
    logic [XLEN-1:0]       new_c;

    csr_seq_ctrl u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .state     (state),
        .ready     (req_ready),
        .accept    (accept)
    );

    csr_perm_check u_perm (
        .addr_hi  (addr_q[CSR_ADDR_W-1:HI_LSB]),
        .op       (op_q),
        .src_zero (zero_q),
        .priv     (priv_q),
        .hit      (rd_hit),
        .verdict  (verdict_c)
    );

    csr_update_calc #(.XLEN(XLEN)) u_calc (
        .op      (op_q),
        .old_val (rd_data),
        .src     (src_q),
        .new_val (new_c)
    );

    // Request capture on acceptance.
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            src_q  <= '0;
            op_q   <= OP_NONE;
            zero_q <= 1'b0;
            priv_q <= 2'b00;
        end else if (accept) begin
            addr_q <= req_addr;
            src_q  <= req_src;
            op_q   <= csr_op_e'(req_op);
            zero_q <= req_src_zero;
            priv_q <= req_priv;
        end
    end

    // Read-and-check phase result capture.
    always_ff @(posedge clk) begin
        if (rst) begin
            old_q     <= '0;
            new_q     <= '0;
            verdict_q <= '0;
        end else if (state == ST_CHECK) begin
            old_q     <= rd_data;
            new_q     <= new_c;
            verdict_q <= verdict_c;
        end
    end

    assign rd_en       = (state == ST_CHECK);
    assign rd_addr     = addr_q;
    assign rsp_done    = (state == ST_WRITE);
    assign wr_en       = rsp_done && verdict_q.do_wr;
    assign wr_addr     = addr_q;
    assign wr_data     = new_q;
    assign rsp_illegal = rsp_done && verdict_q.illegal;
    assign rsp_data    = (rsp_done && !verdict_q.illegal) ? old_q : '0;

    // R9: trap and write never coincide
    a_r9_no_write_on_trap: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal |-> !wr_en);

    // R9: trap indication lasts a single cycle
    a_r9_trap_single: assert property (@(posedge clk) disable iff (rst)
        rsp_illegal |=> !rsp_illegal);

    // R10: a read is followed by the response
    a_r10_read_then_done: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rsp_done);

    // R10: a response is always preceded by a read
    a_r10_done_after_read: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $past(rd_en));

    // R2: read-only registers are never written
    a_r2_no_ro_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (wr_addr[CSR_ADDR_W-1:CSR_ADDR_W-2] != 2'b11));

    // R1: writes only happen with sufficient privilege
    a_r1_priv_ok: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> (priv_q >= wr_addr[CSR_ADDR_W-3:CSR_ADDR_W-4]));

endmodule

// File: tb/sim_csr_rmw_unit.sv
module sim_csr_rmw_unit;

    localparam int XLEN = 32;
    localparam int NREG = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [11:0]     req_addr = '0;
    logic [XLEN-1:0] req_src = '0;
    logic [1:0]      req_op = '0;
    logic            req_src_zero = 1'b0;
    logic [1:0]      req_priv = '0;
    logic            rd_en;
    logic [11:0]     rd_addr;
    logic [XLEN-1:0] rd_data;
    logic            rd_hit;
    logic            wr_en;
    logic [11:0]     wr_addr;
    logic [XLEN-1:0] wr_data;
    logic            rsp_done;
    logic [XLEN-1:0] rsp_data;
    logic            rsp_illegal;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    csr_rmw_unit #(.XLEN(XLEN)) u0 (.*);

    // Storage model: eight decoded addresses.
    logic [11:0]     reg_addr [NREG] = '{12'h340, 12'h341, 12'h140, 12'h040,
                                         12'hC00, 12'hF11, 12'h105, 12'h305};
    logic [XLEN-1:0] store  [NREG];
    logic [XLEN-1:0] shadow [NREG];

    function automatic int find(input logic [11:0] a);
        for (int i = 0; i < NREG; i++) if (reg_addr[i] == a) return i;
        return -1;
    endfunction

    always_comb begin
        rd_hit  = find(rd_addr) >= 0;
        rd_data = rd_hit ? store[find(rd_addr)] : '0;
    end

    always @(posedge clk) if (wr_en && find(wr_addr) >= 0) store[find(wr_addr)] <= wr_data;

    // Scoreboard queues.
    bit              q_ill[$];
    logic [XLEN-1:0] q_data[$];
    bit              q_wr[$];
    logic [XLEN-1:0] q_wdata[$];
    string           q_tag[$];

    task automatic check(input bit ok, input string tag, input logic [XLEN-1:0] act,
                         input logic [XLEN-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares each response with the queued expectation.
    always @(negedge clk) begin
        if (!rst) begin
            if (rsp_done) begin
                if (q_ill.size() == 0) begin
                    check(1'b0, "R10 unexpected response", 32'd1, 32'd0);
                end else begin
                    bit ei, ew; logic [XLEN-1:0] ed, ewd; string t;
                    ei = q_ill.pop_front(); ed = q_data.pop_front();
                    ew = q_wr.pop_front(); ewd = q_wdata.pop_front(); t = q_tag.pop_front();
                    check(rsp_illegal == ei, {t, " illegal"}, {31'd0, rsp_illegal}, {31'd0, ei});
                    check(rsp_data == ed, {t, " data"}, rsp_data, ed);
                    check(wr_en == ew, {t, " wr_en"}, {31'd0, wr_en}, {31'd0, ew});
                    if (ew) check(wr_data == ewd, {t, " wr_data"}, wr_data, ewd);
                end
            end else if (wr_en || rsp_illegal) begin
                check(1'b0, "R9 strobe outside response", {30'd0, wr_en, rsp_illegal}, 32'd0);
            end
        end
    end

    // Driver: computes expectation from the requirements, then issues the request.
    task automatic issue(input string tag, input logic [11:0] a, input logic [XLEN-1:0] s,
                         input logic [1:0] op, input bit z, input logic [1:0] pv);
        int k; bit writes, ill; logic [XLEN-1:0] oldv, newv;
        k      = find(a);
        writes = (op == 2'b01) || (op[1] && !z);
        ill    = (k < 0) || (op == 2'b00) || (pv < a[9:8]) || (writes && a[11:10] == 2'b11);
        oldv   = (k >= 0) ? shadow[k] : '0;
        newv   = (op == 2'b01) ? s : (op == 2'b10) ? (oldv | s) : (oldv & ~s);
        q_ill.push_back(ill);
        q_data.push_back(ill ? '0 : oldv);
        q_wr.push_back(!ill && writes);
        q_wdata.push_back(newv);
        q_tag.push_back(tag);
        if (!ill && writes) shadow[k] = newv;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_src = s; req_op = op;
        req_src_zero = z; req_priv = pv;
        @(negedge clk);
        req_valid = 1'b0;
        // R10: read strobe in the cycle after acceptance, no response yet
        check(rd_en && !rsp_done && !req_ready, {tag, " R10 read phase"},
              {29'd0, rd_en, rsp_done, req_ready}, 32'h4);
        @(negedge clk);
        check(rsp_done, {tag, " R10 response phase"}, {31'd0, rsp_done}, 32'd1);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) begin
            store[i]  = 32'hA5A5_0000 ^ (i * 32'h0013_579B);
            shadow[i] = store[i];
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        check(req_ready && !rd_en && !wr_en && !rsp_done && !rsp_illegal, "R10 reset state",
              {27'd0, req_ready, rd_en, wr_en, rsp_done, rsp_illegal}, 32'h10);

        // R3 R5: swap returns old value and writes source
        issue("R3 swap M", 12'h340, 32'h1234_5678, 2'b01, 1'b0, 2'd3);
        issue("R5 readback", 12'h340, 32'h0, 2'b10, 1'b1, 2'd3);
        // R6: set and clear
        issue("R6 set", 12'h340, 32'hF000_000F, 2'b10, 1'b0, 2'd3);
        issue("R6 clear", 12'h340, 32'h1030_0001, 2'b11, 1'b0, 2'd3);
        // R4: zero-source flag with nonzero operand writes nothing
        issue("R4 set x0", 12'h341, 32'hFFFF_FFFF, 2'b10, 1'b1, 2'd3);
        issue("R4 clear x0", 12'h341, 32'hFFFF_FFFF, 2'b11, 1'b1, 2'd3);
        issue("R4 readback", 12'h341, 32'h0, 2'b10, 1'b1, 2'd3);
        // R3: swap writes even with zero-source flag
        issue("R3 swap x0", 12'h305, 32'h0, 2'b01, 1'b1, 2'd3);
        issue("R3 readback", 12'h305, 32'h0, 2'b10, 1'b1, 2'd3);
        // R1: privilege boundaries
        issue("R1 S on M reg", 12'h340, 32'hDEAD_BEEF, 2'b01, 1'b0, 2'd1);
        issue("R1 M readback", 12'h340, 32'h0, 2'b11, 1'b1, 2'd3);
        issue("R1 S on S reg", 12'h140, 32'h0000_00FF, 2'b10, 1'b0, 2'd1);
        issue("R1 U on S reg", 12'h105, 32'h1, 2'b01, 1'b0, 2'd0);
        issue("R1 U on U reg", 12'h040, 32'h5555_AAAA, 2'b01, 1'b0, 2'd0);
        issue("R1 reserved lvl on S reg", 12'h105, 32'h0F0F_0F0F, 2'b11, 1'b0, 2'd2);
        // R2: read-only registers
        issue("R2 ro read U", 12'hC00, 32'h7, 2'b10, 1'b1, 2'd0);
        issue("R2 ro swap", 12'hC00, 32'h7, 2'b01, 1'b0, 2'd3);
        issue("R2 ro clear", 12'hF11, 32'h1, 2'b11, 1'b0, 2'd3);
        issue("R2 ro read M", 12'hF11, 32'h0, 2'b11, 1'b1, 2'd3);
        issue("R2 ro read S", 12'hF11, 32'h0, 2'b10, 1'b1, 2'd1);
        // R7: undecoded address
        issue("R7 undecoded", 12'h7C0, 32'h1, 2'b01, 1'b0, 2'd3);
        // R8: null operation code
        issue("R8 op none", 12'h340, 32'hFFFF_FFFF, 2'b00, 1'b0, 2'd3);
        // R9: after traps, registers unchanged
        issue("R9 readback", 12'h340, 32'h0, 2'b10, 1'b1, 2'd3);
        // Mixed sequence
        for (int i = 0; i < 40; i++) begin
            issue("R6 mixed", reg_addr[i % NREG], 32'h9E37_79B9 * (i + 1),
                  2'((i % 3) + 1), (i % 5) == 0, 2'((i * 7) % 4));
        end
        check(q_ill.size() == 0, "R10 queue drained", q_ill.size(), 32'd0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule